// File: doc/BRIEF.md
# Windowed Outbound Address Translator

The block rewrites outgoing 64-bit addresses through a table of programmable windows. Each table entry holds an enable bit, a power-of-two window size, a 4 KB aligned source base, a 4 KB aligned translated base and a 32-bit parameter word. An incoming address is compared against every entry at once. The lowest-numbered entry that matches replaces the address bits above the window offset with its translated base. Alongside the new address it reports its parameter word, whether the access is a configuration access or a memory access, and its direction flag. If no entry matches, a miss is flagged and the address goes through unchanged.

Requests use a valid/ready handshake and results come out of a single register stage, so each request takes one cycle. Entries are written and read through a small word-addressed register port. In that port the entry index and the word select are fields of the byte address, so each entry is a block of 32 bytes.

Top module: `addr_xlate_table`

## Requirements
- R1: After reset no response is valid, `req_ready_o` is 1 and every register word of every entry reads as zero.
- R2: Register byte address `cfg_addr_i[7:5]` selects the entry and `cfg_addr_i[4:2]` selects the word: 0 is source low, 1 is source high, 2 is translated low, 3 is translated high, 4 is parameter. Word selects 5 to 7 read as zero and ignore writes. A write stores on the clock edge and a read is combinational.
- R3: In the source-low word, bit 0 is the enable, bits 6:1 are the size exponent S, bits 11:7 read as zero and bits 31:12 are source base bits 31:12. Translated-low bits 11:0 read as zero.
- R4: An entry hits when it is enabled and request address bits 63:S+1 equal the same bits of the source base. The base is {high word, low word bits 31:12, 12'b0}.
- R5: On a hit the result address takes bits 63:S+1 from the translated base and bits S:0 from the request, so the window spans 2^(S+1) bytes.
- R6: When several entries hit, the lowest entry index wins, and `rsp_entry_o` reports that index.
- R7: When no entry hits, `rsp_miss_o` is 1, the result address equals the request address, and the parameter, configuration and direction outputs are 0.
- R8: On a hit, `rsp_param_o` is the entry's parameter word. `rsp_cfg_o` is 1 exactly when parameter bits 3:0 equal 1 (an ID of 0 means memory). `rsp_dir_o` is parameter bit 22.
- R9: With S=27 a 2^28-byte configuration window translates every offset below 2^28 and rejects the address one past its end. With S=63 every address hits and the address passes through.
- R10: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1, and its result is valid on the following cycle. `req_ready_o` equals `!rsp_valid_o || rsp_ready_i`. A result that is not taken stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register byte address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted |
| req_addr_i | input | 64 | Source address |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result taken |
| rsp_addr_o | output | 64 | Translated address |
| rsp_miss_o | output | 1 | No entry hit |
| rsp_cfg_o | output | 1 | Configuration access |
| rsp_dir_o | output | 1 | Direction flag |
| rsp_param_o | output | 32 | Parameter word of the winning entry |
| rsp_entry_o | output | 3 | Index of the winning entry |

## Verification
Random tables use mixed window sizes and bases. Addresses are drawn both inside a chosen window and from the whole 64-bit space, which exercises hit, offset substitution and miss against a bench model. Directed patterns cover several things. Two identical windows at different indices show the priority order. Addresses at the first byte, the last byte and one byte past a 2^28 window test the size decode at its edges. A full-space window shows the widest mask. A stalled result followed by a changed request separates correct holding from overwriting.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [2:0] {
    W_SRC_LO = 3'd0,
    W_SRC_HI = 3'd1,
    W_TR_LO  = 3'd2,
    W_TR_HI  = 3'd3,
    W_PARAM  = 3'd4
  } word_e;

  localparam int unsigned PAGE_BITS = 12;

  // mask of in-window offset bits for size exponent s (window = 2^(s+1))
  function automatic logic [63:0] off_mask(input logic [5:0] s);
    logic [6:0] n;
    n = {1'b0, s} + 7'd1;
    if (n >= 7'd64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction
endpackage

// File: rtl/xlt_entry.sv
module xlt_entry
  import xlt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [2:0]  word_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [63:0] addr_i,
  output logic        hit_o,
  output logic [63:0] xaddr_o,
  output logic [31:0] param_o
);
  logic        en_q;
  logic [5:0]  sz_q;
  logic [63:PAGE_BITS] src_q, trs_q;
  logic [31:0] par_q;
  logic [63:0] msk, src_base, trs_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sz_q  <= '0;
      src_q <= '0;
      trs_q <= '0;
      par_q <= '0;
    end else if (wr_i) begin
      case (word_i)
        W_SRC_LO: begin
          en_q  <= wdata_i[0];
          sz_q  <= wdata_i[6:1];
          src_q[31:PAGE_BITS] <= wdata_i[31:PAGE_BITS];
        end
        W_SRC_HI: src_q[63:32] <= wdata_i;
        W_TR_LO:  trs_q[31:PAGE_BITS] <= wdata_i[31:PAGE_BITS];
        W_TR_HI:  trs_q[63:32] <= wdata_i;
        W_PARAM:  par_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (word_i)
      W_SRC_LO: rdata_o = {src_q[31:PAGE_BITS], 5'd0, sz_q, en_q};
      W_SRC_HI: rdata_o = src_q[63:32];
      W_TR_LO:  rdata_o = {trs_q[31:PAGE_BITS], 12'd0};
      W_TR_HI:  rdata_o = trs_q[63:32];
      W_PARAM:  rdata_o = par_q;
      default:  rdata_o = '0;
    endcase
  end

  assign msk      = off_mask(sz_q);
  assign src_base = {src_q, {PAGE_BITS{1'b0}}};
  assign trs_base = {trs_q, {PAGE_BITS{1'b0}}};
  assign hit_o    = en_q && (((addr_i ^ src_base) & ~msk) == '0);
  assign xaddr_o  = (trs_base & ~msk) | (addr_i & msk);
  assign param_o  = par_q;

  // R5: the in-window low byte bit always survives translation
  assert_offset_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (xaddr_o[0] == addr_i[0]));
endmodule

// File: rtl/xlt_pick.sv
module xlt_pick #(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] hit_i,
  output logic [N_ENT-1:0] grant_o,
  output logic [IDX_W-1:0] sel_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    sel_o   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        sel_o      = IDX_W'(i);
      end
    end
  end
  assign any_o = |hit_i;

  assert_onehot_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && (any_o == (grant_o != '0)));
  assert_low_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i[0] |-> (sel_o == '0));
endmodule

// File: rtl/addr_xlate_table.sv
module addr_xlate_table
  import xlt_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = $clog2(N_ENT),
  localparam int unsigned CA_W  = IDX_W + 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CA_W-1:0]  cfg_addr_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [63:0]      req_addr_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [63:0]      rsp_addr_o,
  output logic             rsp_miss_o,
  output logic             rsp_cfg_o,
  output logic             rsp_dir_o,
  output logic [31:0]      rsp_param_o,
  output logic [IDX_W-1:0] rsp_entry_o
);
  localparam logic [3:0] ID_CFG = 4'd1;
  localparam int unsigned DIR_BIT = 22;

  logic [N_ENT-1:0] hit, grant;
  logic [63:0]      xaddr [N_ENT];
  logic [31:0]      param [N_ENT];
  logic [31:0]      rdat  [N_ENT];
  logic [IDX_W-1:0] sel, ent_idx;
  logic             any_hit, accept;
  logic [2:0]       word;

  assign ent_idx = cfg_addr_i[CA_W-1:5];
  assign word    = cfg_addr_i[4:2];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    xlt_entry u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cfg_we_i && (ent_idx == IDX_W'(g))),
      .word_i  (word),
      .wdata_i (cfg_wdata_i),
      .rdata_o (rdat[g]),
      .addr_i  (req_addr_i),
      .hit_o   (hit[g]),
      .xaddr_o (xaddr[g]),
      .param_o (param[g])
    );
  end

  assign cfg_rdata_o = rdat[ent_idx];

  xlt_pick #(.N_ENT(N_ENT)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .grant_o (grant),
    .sel_o   (sel),
    .any_o   (any_hit)
  );

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_miss_o  <= 1'b0;
      rsp_cfg_o   <= 1'b0;
      rsp_dir_o   <= 1'b0;
      rsp_param_o <= '0;
      rsp_entry_o <= '0;
    end else if (accept) begin
      rsp_valid_o <= 1'b1;
      rsp_miss_o  <= !any_hit;
      rsp_entry_o <= sel;
      if (any_hit) begin
        rsp_addr_o  <= xaddr[sel];
        rsp_param_o <= param[sel];
        rsp_cfg_o   <= param[sel][3:0] == ID_CFG;
        rsp_dir_o   <= param[sel][DIR_BIT];
      end else begin
        rsp_addr_o  <= req_addr_i;
        rsp_param_o <= '0;
        rsp_cfg_o   <= 1'b0;
        rsp_dir_o   <= 1'b0;
      end
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_param_o)));
  assert_ready_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> req_ready_o);
  assert_miss_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (grant == '0)) |=> (rsp_miss_o && rsp_addr_o == $past(req_addr_i)));
  assert_miss_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (rsp_param_o == '0 && !rsp_cfg_o && !rsp_dir_o));
endmodule

// File: tb/addr_xlate_table_test.sv
module addr_xlate_table_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic        rsp_miss, rsp_cfg, rsp_dir;
  logic [31:0] rsp_param;
  logic [2:0]  rsp_entry;

  int n_chk = 0;
  int n_bad = 0;

  // shadow table
  logic        sh_en  [8];
  logic [5:0]  sh_s   [8];
  logic [63:0] sh_src [8];
  logic [63:0] sh_trs [8];
  logic [31:0] sh_par [8];

  always #5 clk = ~clk;

  addr_xlate_table uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_addr_o(rsp_addr),
    .rsp_miss_o(rsp_miss), .rsp_cfg_o(rsp_cfg), .rsp_dir_o(rsp_dir),
    .rsp_param_o(rsp_param), .rsp_entry_o(rsp_entry)
  );

  function automatic logic [63:0] mk(input logic [5:0] s);
    int n = int'(s) + 1;
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int e, input int w, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = {3'(e), 3'(w), 2'b00};
    cfg_wdata = d;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int e, input logic en, input logic [5:0] s,
                      input logic [63:0] src, input logic [63:0] trs, input logic [31:0] par);
    sh_en[e] = en; sh_s[e] = s;
    sh_src[e] = {src[63:12], 12'd0};
    sh_trs[e] = {trs[63:12], 12'd0};
    sh_par[e] = par;
    wr(e, 1, src[63:32]);
    wr(e, 2, trs[31:0]);
    wr(e, 3, trs[63:32]);
    wr(e, 4, par);
    wr(e, 0, {src[31:12], 5'b10101, s, en});
  endtask

  task automatic xact(input string req, input logic [63:0] a);
    logic [63:0] xa = a;
    logic miss = 1'b1;
    logic [31:0] par = '0;
    logic [2:0] ent = '0;
    for (int i = 7; i >= 0; i--) begin
      if (sh_en[i] && (((a ^ sh_src[i]) & ~mk(sh_s[i])) == '0)) begin
        miss = 1'b0;
        ent = 3'(i);
        par = sh_par[i];
        xa = (sh_trs[i] & ~mk(sh_s[i])) | (a & mk(sh_s[i]));
      end
    end
    @(negedge clk);
    req_addr = a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " addr"}, rsp_addr, xa);
    chk({req, " miss"}, 64'(rsp_miss), 64'(miss));
    chk({req, " param"}, rsp_param, 64'(par));
    chk({req, " cfg"}, 64'(rsp_cfg), 64'(!miss && par[3:0] == 4'd1));
    chk({req, " dir"}, 64'(rsp_dir), 64'(!miss && par[22]));
    if (!miss) chk({req, " entry"}, 64'(rsp_entry), 64'(ent));
  endtask

  task automatic clear_all();
    for (int e = 0; e < 8; e++) prog(e, 1'b0, 6'd0, 64'd0, 64'd0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < 8; i++) begin
      sh_en[i] = 0; sh_s[i] = 0; sh_src[i] = 0; sh_trs[i] = 0; sh_par[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    for (int e = 0; e < 8; e++)
      for (int w = 0; w < 5; w++) begin
        cfg_addr = {3'(e), 3'(w), 2'b00};
        #1 chk("R1 reg zero", 64'(cfg_rdata), 64'd0);
      end
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: layout and field masking
    prog(3, 1'b1, 6'd13, 64'h0000_0012_3456_7fff, 64'hAAAA_BBBB_CCCC_DFFF, 32'h0040_0001);
    cfg_addr = {3'd3, 3'd0, 2'b00}; #1 chk("R3 src lo fields", 64'(cfg_rdata), {32'd0, 20'h34567, 5'd0, 6'd13, 1'b1});
    cfg_addr = {3'd3, 3'd1, 2'b00}; #1 chk("R2 src hi", 64'(cfg_rdata), 64'h12);
    cfg_addr = {3'd3, 3'd2, 2'b00}; #1 chk("R3 trs lo mask", 64'(cfg_rdata), 64'hCCCC_D000);
    cfg_addr = {3'd3, 3'd3, 2'b00}; #1 chk("R2 trs hi", 64'(cfg_rdata), 64'hAAAA_BBBB);
    cfg_addr = {3'd3, 3'd4, 2'b00}; #1 chk("R2 param", 64'(cfg_rdata), 64'h0040_0001);
    wr(3, 6, 32'hFFFF_FFFF);
    cfg_addr = {3'd3, 3'd6, 2'b00}; #1 chk("R2 unused word", 64'(cfg_rdata), 64'd0);
    cfg_addr = {3'd3, 3'd4, 2'b00}; #1 chk("R2 param after unused write", 64'(cfg_rdata), 64'h0040_0001);
    cfg_addr = {3'd2, 3'd4, 2'b00}; #1 chk("R2 other entry", 64'(cfg_rdata), 64'd0);

    // R4/R5/R8: single hit, window 2^14
    xact("R5 hit base", 64'h0000_0012_3456_4000);
    xact("R5 hit top", 64'h0000_0012_3456_7fff);
    xact("R4 just below", 64'h0000_0012_3456_3fff);
    xact("R7 miss", 64'hdead_beef_0000_1234);

    // R6: overlapping windows
    prog(5, 1'b1, 6'd13, 64'h0000_0012_3456_4000, 64'h1111_0000_0000_0000, 32'h0000_0000);
    xact("R6 two hits low wins", 64'h0000_0012_3456_5abc);
    prog(3, 1'b0, 6'd13, 64'h0000_0012_3456_4000, 64'hAAAA_BBBB_CCCC_D000, 32'h0040_0001);
    xact("R6 disabled falls to higher", 64'h0000_0012_3456_5abc);

    // R9: 2^28 config window and full-space window
    clear_all();
    prog(1, 1'b1, 6'd27, 64'h0000_0040_3000_0000, 64'd0, 32'h0000_0001);
    xact("R9 cfg first", 64'h0000_0040_3000_0000);
    xact("R9 cfg last", 64'h0000_0040_3fff_ffff);
    xact("R9 cfg past end", 64'h0000_0040_4000_0000);
    prog(7, 1'b1, 6'd63, 64'h0, 64'h0, 32'h0040_0000);
    xact("R9 full space", 64'hfedc_ba98_7654_3210);

    // R10: backpressure
    clear_all();
    prog(0, 1'b1, 6'd20, 64'h0000_0000_8000_0000, 64'h0000_0009_0000_0000, 32'h0000_0000);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = 64'h0000_0000_8001_2345;
    req_valid = 1'b1;
    @(negedge clk);
    chk("R10 latency valid", 64'(rsp_valid), 64'd1);
    chk("R10 ready low", 64'(req_ready), 64'd0);
    req_addr = 64'h0000_0000_8000_0abc;
    repeat (2) @(negedge clk);
    chk("R10 hold", rsp_addr, 64'h0000_0009_0001_2345);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 next result", rsp_addr, 64'h0000_0009_0000_0abc);
    @(negedge clk);
    chk("R10 drained", 64'(rsp_valid), 64'd0);

    // random tables and addresses
    for (int r = 0; r < 6; r++) begin
      for (int e = 0; e < 8; e++) begin
        logic [5:0] s = 6'(11 + ($urandom % 24));
        logic [63:0] b = {$urandom, $urandom} & ~mk(s);
        logic [31:0] p = $urandom & 32'h0040_00ff;
        p[3:0] = 4'($urandom % 2);
        prog(e, ($urandom % 4) != 0, s, b, {$urandom, $urandom}, p);
      end
      for (int t = 0; t < 40; t++) begin
        int k = $urandom % 8;
        logic [63:0] a;
        if (t % 4 == 3) a = {$urandom, $urandom};
        else a = sh_src[k] | ({$urandom, $urandom} & mk(sh_s[k]));
        xact("R4 R5 R6 R8 random", a);
      end
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule